// File: doc/BRIEF.md
# Zero-Crossing Gain Update Controller

This block decides when a requested gain setting reaches the gain stages of a two-channel recording path. A gain change that lands in the middle of a waveform causes an audible click. When zero-cross operation is enabled, a written gain code is therefore held as pending. Each channel then applies it on its own, at the first zero crossing of that channel's sample stream or when a selectable timeout expires. The timeout is 256, 512, 1024 or 2048 sample periods. When zero-cross operation is disabled, a written code takes effect at once.

The same mechanism is instantiated a second time for a 2-bit preamplifier gain. That path has a fixed timeout of 2048 sample periods and uses the crossings detected on the converter sample streams. When the converter is powered off, the preamplifier gain changes immediately. The gain stages themselves lie outside this block. The outputs are the active gain codes, one per channel and per path.

Top module: `zcg_top`

## Requirements
- R1: After reset both converter-path gains read 28h (0 dB) and both preamplifier gains read 2'b10 (+28 dB; the code map is 00 = +13 dB, 01 = +18 dB, 10 = +28 dB, 11 = +33 dB).
- R2: With zc_en low, a converter gain write appears on both channel outputs at the clock edge that samples the write. Code 00h (mute) and codes 01h..60h pass unchanged. Codes above 60h are clamped to 60h.
- R3: With zc_en high, a write is held pending. Each channel commits the pending code on the first strobed sample that is zero or whose sign bit differs from that channel's previous strobed sample, independently of the other channel.
- R4: With no crossing, a pending code commits on the Nth sample strobe after the write, where N = 256 << tmo_sel (00: 256, 01: 512, 10: 1024, 11: 2048).
- R5: A write that arrives while a code is pending replaces that code and restarts both channels' timeout counts from zero.
- R6: Driving zc_en low while a code is pending commits it on both channels at the next clock edge.
- R7: The preamplifier path commits at a crossing or after exactly 2048 strobes, whatever tmo_sel is, while adc_pwr is high. With adc_pwr low, writes and pending codes take effect at the next edge.
- R8: Sample values presented while smp_stb is low are ignored: they neither commit a pending code nor act as the previous sample for crossing detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One-cycle strobe at the sample rate |
| smp_l | input | SW (20) | Left channel signed sample |
| smp_r | input | SW (20) | Right channel signed sample |
| pga_wr | input | 1 | Converter-path gain write pulse |
| pga_code | input | 7 | Requested converter-path gain code |
| zc_en | input | 1 | Zero-cross operation enable for the converter path |
| tmo_sel | input | 2 | Converter-path timeout select |
| pre_wr | input | 1 | Preamplifier gain write pulse |
| pre_code | input | 2 | Requested preamplifier gain code |
| adc_pwr | input | 1 | Converter powered on |
| pga_gain_l | output | 7 | Active left converter-path gain |
| pga_gain_r | output | 7 | Active right converter-path gain |
| pre_gain_l | output | 2 | Active left preamplifier gain |
| pre_gain_r | output | 2 | Active right preamplifier gain |

## Verification
Immediate writes are driven through a table of codes spanning mute, the 0 dB point, the top valid code and two out-of-range codes, which separates clamping from pass-through. Crossing tests send a sign flip on one channel and an exact zero on the other, so a channel that follows its neighbour, or a detector that misses the zero case, shows at once. Steady positive streams run each timeout selection to one strobe short of its limit and then to the limit, exposing off-by-one counts. A rewrite partway through a count, and sign changes presented without a strobe, tell restart and strobe qualification apart from a free-running count.

// File: rtl/zcg_pkg.sv
package zcg_pkg;
  localparam int PGA_W = 7;
  localparam int PRE_W = 2;
  localparam logic [PGA_W-1:0] PGA_MAX = 7'h60;
  localparam logic [PGA_W-1:0] PGA_RST = 7'h28;
  localparam logic [PRE_W-1:0] PRE_RST = 2'b10;

  // Limit a requested converter-path code to the valid range.
  function automatic logic [PGA_W-1:0] pga_clamp(input logic [PGA_W-1:0] code);
    return (code > PGA_MAX) ? PGA_MAX : code;
  endfunction
endpackage

// File: rtl/zcg_xdet.sv
module zcg_xdet #(
  parameter int SW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb,
  input  logic [SW-1:0] smp,
  output logic          xing
);
  logic [SW-1:0] prev_q;

  function automatic logic is_crossing(input logic [SW-1:0] prev, input logic [SW-1:0] cur);
    return (cur == '0) || (prev[SW-1] != cur[SW-1]);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   prev_q <= '0;
    else if (stb) prev_q <= smp;
  end

  assign xing = stb && is_crossing(prev_q, smp);
endmodule

// File: rtl/zcg_slice.sv
module zcg_slice #(
  parameter int            GW      = 7,
  parameter int            CW      = 11,
  parameter logic [GW-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [GW-1:0] code,
  input  logic          imm,
  input  logic          stb,
  input  logic          xing,
  input  logic [CW:0]   lim,
  output logic [GW-1:0] gain,
  output logic          pend,
  output logic [CW-1:0] cnt,
  output logic          commit
);
  logic [GW-1:0] pend_code;
  logic          tmo;

  assign tmo    = pend && stb && ({1'b0, cnt} == lim - 1'b1);
  assign commit = pend && !wr && (imm || xing || tmo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain      <= RST_VAL;
      pend_code <= RST_VAL;
      pend      <= 1'b0;
      cnt       <= '0;
    end else if (wr) begin
      cnt       <= '0;
      pend_code <= code;
      if (imm) begin
        gain <= code;
        pend <= 1'b0;
      end else begin
        pend <= 1'b1;
      end
    end else if (commit) begin
      gain <= pend_code;
      pend <= 1'b0;
      cnt  <= '0;
    end else if (pend && stb) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/zcg_top.sv
module zcg_top
  import zcg_pkg::*;
#(
  parameter int          SW       = 20,
  parameter int          TMO_BASE = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic [SW-1:0]    smp_l,
  input  logic [SW-1:0]    smp_r,
  input  logic             pga_wr,
  input  logic [PGA_W-1:0] pga_code,
  input  logic             zc_en,
  input  logic [1:0]       tmo_sel,
  input  logic             pre_wr,
  input  logic [PRE_W-1:0] pre_code,
  input  logic             adc_pwr,
  output logic [PGA_W-1:0] pga_gain_l,
  output logic [PGA_W-1:0] pga_gain_r,
  output logic [PRE_W-1:0] pre_gain_l,
  output logic [PRE_W-1:0] pre_gain_r
);
  localparam int TMO_MAX = TMO_BASE * 8;
  localparam int CW      = $clog2(TMO_MAX);
  localparam int LIM_W   = CW + 1;

  logic [SW-1:0]    smp_a    [2];
  logic             xing     [2];
  logic [PGA_W-1:0] pga_g    [2];
  logic [PRE_W-1:0] pre_g    [2];
  logic [CW-1:0]    pga_cnt  [2];
  logic [CW-1:0]    pre_cnt  [2];
  logic [1:0]       pga_pend;
  logic [1:0]       pga_commit;
  logic [1:0]       pre_pend;
  logic [1:0]       pre_commit;
  logic [LIM_W-1:0] pga_lim;
  logic [LIM_W-1:0] pre_lim;
  logic [PGA_W-1:0] pga_code_ok;

  assign smp_a[0]    = smp_l;
  assign smp_a[1]    = smp_r;
  assign pga_lim     = LIM_W'(TMO_BASE) << tmo_sel;
  assign pre_lim     = LIM_W'(TMO_MAX);
  assign pga_code_ok = pga_clamp(pga_code);

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    zcg_xdet #(.SW(SW)) u_xdet (
      .clk(clk), .rst_n(rst_n), .stb(smp_stb), .smp(smp_a[ch]), .xing(xing[ch])
    );

    zcg_slice #(.GW(PGA_W), .CW(CW), .RST_VAL(PGA_RST)) u_pga (
      .clk(clk), .rst_n(rst_n), .wr(pga_wr), .code(pga_code_ok), .imm(!zc_en),
      .stb(smp_stb), .xing(xing[ch]), .lim(pga_lim), .gain(pga_g[ch]),
      .pend(pga_pend[ch]), .cnt(pga_cnt[ch]), .commit(pga_commit[ch])
    );

    zcg_slice #(.GW(PRE_W), .CW(CW), .RST_VAL(PRE_RST)) u_pre (
      .clk(clk), .rst_n(rst_n), .wr(pre_wr), .code(pre_code), .imm(!adc_pwr),
      .stb(smp_stb), .xing(xing[ch]), .lim(pre_lim), .gain(pre_g[ch]),
      .pend(pre_pend[ch]), .cnt(pre_cnt[ch]), .commit(pre_commit[ch])
    );
  end

  assign pga_gain_l = pga_g[0];
  assign pga_gain_r = pga_g[1];
  assign pre_gain_l = pre_g[0];
  assign pre_gain_r = pre_g[1];
endmodule

// File: rtl/zcg_chk.sv
module zcg_chk #(
  parameter int CW    = 11,
  parameter int LIM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_stb,
  input logic             pga_wr,
  input logic [6:0]       pga_code,
  input logic             zc_en,
  input logic             pre_wr,
  input logic [1:0]       pre_code,
  input logic             adc_pwr,
  input logic [6:0]       pga_gain_l,
  input logic [6:0]       pga_gain_r,
  input logic [1:0]       pre_gain_l,
  input logic [1:0]       pre_gain_r,
  input logic [1:0]       pga_pend,
  input logic [CW-1:0]    pga_cnt_l,
  input logic [CW-1:0]    pga_cnt_r,
  input logic [LIM_W-1:0] pga_lim
);
  // R2
  imm_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_wr && !zc_en) |=> (pga_gain_l == (($past(pga_code) > 7'h60) ? 7'h60 : $past(pga_code)))
                        && (pga_gain_r == pga_gain_l));
  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_gain_l <= 7'h60) && (pga_gain_r <= 7'h60));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_wr && zc_en) |=> $stable(pga_gain_l) && $stable(pga_gain_r));
  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pga_cnt_l} < pga_lim) && ({1'b0, pga_cnt_r} < pga_lim));
  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_wr && zc_en) |=> (pga_pend == 2'b11) && (pga_cnt_l == '0) && (pga_cnt_r == '0));
  // R6
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pga_pend != 2'b00 && !zc_en && !pga_wr) |=> (pga_pend == 2'b00));
  // R7
  pre_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_wr && !adc_pwr) |=> (pre_gain_l == $past(pre_code)) && (pre_gain_r == $past(pre_code)));
  // R8
  no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_stb && !pga_wr && zc_en) |=> $stable(pga_gain_l) && $stable(pga_gain_r));
endmodule

bind zcg_top zcg_chk #(.CW(CW), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .pga_wr(pga_wr), .pga_code(pga_code),
  .zc_en(zc_en), .pre_wr(pre_wr), .pre_code(pre_code), .adc_pwr(adc_pwr),
  .pga_gain_l(pga_gain_l), .pga_gain_r(pga_gain_r), .pre_gain_l(pre_gain_l),
  .pre_gain_r(pre_gain_r), .pga_pend(pga_pend), .pga_cnt_l(pga_cnt[0]),
  .pga_cnt_r(pga_cnt[1]), .pga_lim(pga_lim)
);

// File: tb/zcg_top_bench.sv
module zcg_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 20;
  localparam int NV = 7;
  localparam logic [6:0] VIN [NV] = '{7'h00, 7'h01, 7'h60, 7'h61, 7'h7F, 7'h3C, 7'h28};
  localparam logic [6:0] VEX [NV] = '{7'h00, 7'h01, 7'h60, 7'h60, 7'h60, 7'h3C, 7'h28};

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_stb = 1'b0, pga_wr = 1'b0, zc_en = 1'b0, pre_wr = 1'b0, adc_pwr = 1'b1;
  logic [SW-1:0] smp_l = '0, smp_r = '0;
  logic [6:0] pga_code = '0;
  logic [1:0] tmo_sel = 2'b11, pre_code = '0;
  logic [6:0] pga_gain_l, pga_gain_r;
  logic [1:0] pre_gain_l, pre_gain_r;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [6:0] cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  zcg_top #(.SW(SW)) u_zcg_top (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .smp_l(smp_l), .smp_r(smp_r),
    .pga_wr(pga_wr), .pga_code(pga_code), .zc_en(zc_en), .tmo_sel(tmo_sel),
    .pre_wr(pre_wr), .pre_code(pre_code), .adc_pwr(adc_pwr),
    .pga_gain_l(pga_gain_l), .pga_gain_r(pga_gain_r),
    .pre_gain_l(pre_gain_l), .pre_gain_r(pre_gain_r)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic strobe(input int sl, input int sr);
    smp_stb = 1'b1; smp_l = SW'(sl); smp_r = SW'(sr);
    tick();
    smp_stb = 1'b0;
  endtask

  task automatic wr_pga(input logic [6:0] c);
    pga_wr = 1'b1; pga_code = c;
    tick();
    pga_wr = 1'b0;
  endtask

  task automatic wr_pre(input logic [1:0] c);
    pre_wr = 1'b1; pre_code = c;
    tick();
    pre_wr = 1'b0;
  endtask

  task automatic chk_pga(input string tag, input logic [6:0] el, input logic [6:0] er);
    chk(pga_gain_l == el, {tag, " left"}, pga_gain_l, el);
    chk(pga_gain_r == er, {tag, " right"}, pga_gain_r, er);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 reset values
    chk_pga("R1 reset pga", 7'h28, 7'h28);
    chk(pre_gain_l == 2'b10 && pre_gain_r == 2'b10, "R1 reset pre", {pre_gain_l, pre_gain_r}, 4'hA);

    // R2 immediate writes, table driven
    zc_en = 1'b0;
    for (int i = 0; i < NV; i++) begin
      wr_pga(VIN[i]);
      chk_pga("R2 immediate", VEX[i], VEX[i]);
    end
    cur = 7'h28;

    // R3 independent crossing commit
    zc_en = 1'b1; tmo_sel = 2'b11;
    strobe(100, 100);
    wr_pga(7'h50);
    chk_pga("R3 pending held", cur, cur);
    strobe(-5, 100);
    chk_pga("R3 left sign change", 7'h50, cur);
    strobe(100, 0);
    chk_pga("R3 right zero sample", 7'h50, 7'h50);

    // R8 unstrobed samples ignored
    wr_pga(7'h30);
    smp_l = -7; smp_r = -7;
    tick(); tick(); tick();
    chk_pga("R8 no strobe", 7'h50, 7'h50);
    strobe(100, 100);
    chk_pga("R8 unstrobed not previous", 7'h50, 7'h50);

    // R6 disabling zero-cross flushes pending
    zc_en = 1'b0;
    tick();
    chk_pga("R6 flush", 7'h30, 7'h30);
    zc_en = 1'b1;
    cur = 7'h30;

    // R4 timeout per selection
    for (int s = 0; s < 4; s++) begin
      logic [6:0] nc;
      nc = 7'h10 + 7'(s);
      tmo_sel = 2'(s);
      wr_pga(nc);
      repeat ((256 << s) - 1) strobe(100, 100);
      chk_pga("R4 before timeout", cur, cur);
      strobe(100, 100);
      chk_pga("R4 at timeout", nc, nc);
      cur = nc;
    end

    // R5 rewrite replaces code and restarts count
    tmo_sel = 2'b00;
    wr_pga(7'h44);
    repeat (200) strobe(100, 100);
    wr_pga(7'h22);
    repeat (200) strobe(100, 100);
    chk_pga("R5 restarted count", cur, cur);
    repeat (56) strobe(100, 100);
    chk_pga("R5 replaced code", 7'h22, 7'h22);

    // R7 preamp path
    adc_pwr = 1'b0;
    wr_pre(2'b00);
    chk(pre_gain_l == 2'b00 && pre_gain_r == 2'b00, "R7 pre immediate", {pre_gain_l, pre_gain_r}, 0);
    adc_pwr = 1'b1;
    wr_pre(2'b11);
    repeat (256) strobe(100, 100);
    chk(pre_gain_l == 2'b00, "R7 pre ignores tmo_sel", pre_gain_l, 0);
    repeat (1791) strobe(100, 100);
    chk(pre_gain_l == 2'b00, "R7 pre before 2048", pre_gain_l, 0);
    strobe(100, 100);
    chk(pre_gain_l == 2'b11 && pre_gain_r == 2'b11, "R7 pre at 2048", {pre_gain_l, pre_gain_r}, 4'hF);
    wr_pre(2'b01);
    strobe(-3, 100);
    chk(pre_gain_l == 2'b01 && pre_gain_r == 2'b11, "R7 pre left crossing", {pre_gain_l, pre_gain_r}, 4'h7);
    adc_pwr = 1'b0;
    tick();
    chk(pre_gain_r == 2'b01, "R7 pre power-off flush", pre_gain_r, 1);

    finish_run();
  end
endmodule